// File: doc/BRIEF.md
# Modem Control Register with Loopback Routing

This block holds the modem control register of a UART in its basic, non-extended register set. The register sits in bank 0 at offset 4. Its low bits drive the active-low terminal-ready and request-to-send pins. One bit gates the UART's interrupt request. Another bit turns on a diagnostic loopback. In loopback, the outgoing control bits are routed back into the modem status lines that the rest of the UART reads. The external status pins are then ignored, and the two outgoing pins are parked in their inactive (high) state.

The loopback enable is a single state bit that is shared with a second control register. That register's write strobe and loopback value arrive on a separate port, and `loop_en` reports the shared bit so the second register can read it back. If both registers write in the same cycle, the modem control register write wins.

Top module: `modem_ctl_loop`

## Requirements
- R1: After reset, `mcr_rdata` is 0, `loop_en` is 0, `dtr_n_pin` and `rts_n_pin` are 1, and `irq_out` is 0.
- R2: A write on `mcr_wr` stores `mcr_wdata[4:0]`, visible on `mcr_rdata[4:0]` from the next cycle. `mcr_rdata[7:5]` always reads 0. Without any write, the register holds its value.
- R3: With bit 4 clear (normal mode), `dtr_n_pin` is the inverse of bit 0 and `rts_n_pin` is the inverse of bit 1.
- R4: In normal mode, `dsr`, `cts`, `ri` and `dcd` are the inverses of `dsr_n_pin`, `cts_n_pin`, `ri_n_pin` and `dcd_n_pin`. Bit 2 has no effect on any output.
- R5: In normal mode, `irq_out` equals `irq_raw` AND bit 3.
- R6: With bit 4 set (loopback), `dtr_n_pin` and `rts_n_pin` are both 1, whatever the values of bits 0 and 1.
- R7: In loopback, `dsr`=bit 0, `cts`=bit 1, `ri`=bit 2 and `dcd`=bit 3. The four external status pins have no effect.
- R8: In loopback, `irq_out` equals `irq_raw`, whatever the value of bit 3.
- R9: A write on `alt_loop_wr` without `mcr_wr` sets bit 4 to `alt_loop_val` in the next cycle and leaves bits 3..0 unchanged. `loop_en` always equals `mcr_rdata[4]`.
- R10: When `mcr_wr` and `alt_loop_wr` are both high in one cycle, bit 4 takes `mcr_wdata[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_wr | input | 1 | Write strobe for the modem control register |
| mcr_wdata | input | 8 | Write data |
| mcr_rdata | output | 8 | Register read-back |
| alt_loop_wr | input | 1 | Write strobe from the second register that shares the loopback bit |
| alt_loop_val | input | 1 | Loopback value from the second register |
| loop_en | output | 1 | Shared loopback bit |
| dsr_n_pin | input | 1 | External data-set-ready, active low |
| cts_n_pin | input | 1 | External clear-to-send, active low |
| ri_n_pin | input | 1 | External ring indicator, active low |
| dcd_n_pin | input | 1 | External carrier detect, active low |
| dtr_n_pin | output | 1 | Terminal-ready pin, active low |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| dsr | output | 1 | Effective data-set-ready, active high |
| cts | output | 1 | Effective clear-to-send, active high |
| ri | output | 1 | Effective ring indicator, active high |
| dcd | output | 1 | Effective carrier detect, active high |
| irq_raw | input | 1 | Interrupt request from the UART core |
| irq_out | output | 1 | Gated interrupt request |

## Verification
All outputs are combinational from the five stored bits, so a wrong stored bit shows at the ports in the cycle after the write that caused it. A wrong bit shows in two places. It shows on `mcr_rdata`. It also shows either on the pins and gate (normal mode) or on the looped status lines (loopback). A mix-up between the two modes shows as pins that are not parked high, or as status lines that follow the external pins when they should not. A mix-up in the alias priority shows only when both strobes are high in one cycle. For that reason, the collision is exercised in both directions.

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcr_wr,
  input  logic [7:0] mcr_wdata,
  output logic [7:0] mcr_rdata,
  input  logic       alt_loop_wr,
  input  logic       alt_loop_val,
  output logic       loop_en,
  input  logic       dsr_n_pin,
  input  logic       cts_n_pin,
  input  logic       ri_n_pin,
  input  logic       dcd_n_pin,
  output logic       dtr_n_pin,
  output logic       rts_n_pin,
  output logic       dsr,
  output logic       cts,
  output logic       ri,
  output logic       dcd,
  input  logic       irq_raw,
  output logic       irq_out
);

  logic [3:0] ctl_q;
  logic       loop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= 4'b0;
      loop_q <= 1'b0;
    end else if (mcr_wr) begin
      ctl_q  <= mcr_wdata[3:0];
      loop_q <= mcr_wdata[4];
    end else if (alt_loop_wr) begin
      loop_q <= alt_loop_val;
    end
  end

  assign loop_en   = loop_q;
  assign mcr_rdata = {3'b000, loop_q, ctl_q};

  assign dtr_n_pin = loop_q | ~ctl_q[0];
  assign rts_n_pin = loop_q | ~ctl_q[1];

  assign dsr = loop_q ? ctl_q[0] : ~dsr_n_pin;
  assign cts = loop_q ? ctl_q[1] : ~cts_n_pin;
  assign ri  = loop_q ? ctl_q[2] : ~ri_n_pin;
  assign dcd = loop_q ? ctl_q[3] : ~dcd_n_pin;

  assign irq_out = irq_raw & (loop_q | ctl_q[3]);

  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_wr |=> mcr_rdata[4:0] == $past(mcr_wdata[4:0]));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcr_wr && !alt_loop_wr) |=> $stable(mcr_rdata));
  a_r3_pins_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (dtr_n_pin != mcr_rdata[0]) && (rts_n_pin != mcr_rdata[1]));
  a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !mcr_rdata[3]) |-> !irq_out);
  a_r6_pins_parked: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> dtr_n_pin && rts_n_pin);
  a_r7_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> {dsr, cts, ri, dcd} == {mcr_rdata[0], mcr_rdata[1], mcr_rdata[2], mcr_rdata[3]});
  a_r8_irq_forced: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> irq_out == irq_raw);
  a_r9_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_loop_wr && !mcr_wr) |=> loop_en == $past(alt_loop_val) && $stable(mcr_rdata[3:0]));
  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_loop_wr && mcr_wr) |=> loop_en == $past(mcr_wdata[4]));

endmodule

// File: tb/modem_ctl_loop_test.sv
module modem_ctl_loop_test;
  logic clk = 0, rst_n = 0;
  logic mcr_wr = 0, alt_loop_wr = 0, alt_loop_val = 0, irq_raw = 0;
  logic [7:0] mcr_wdata = 0;
  logic dsr_n_pin = 1, cts_n_pin = 1, ri_n_pin = 1, dcd_n_pin = 1;
  logic [7:0] mcr_rdata;
  logic loop_en, dtr_n_pin, rts_n_pin, dsr, cts, ri, dcd, irq_out;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  modem_ctl_loop uut (.*);

  // {wdata[4:0], {dsr_n,cts_n,ri_n,dcd_n}, irq_raw, expected {dtr_n,rts_n,dsr,cts,ri,dcd,irq_out}}
  localparam logic [16:0] VECS [9] = '{
    {5'b00000, 4'b1111, 1'b1, 7'b1100000},  // R3 R4 R5 idle
    {5'b00011, 4'b0101, 1'b1, 7'b0010100},  // R3 R4 R5 gate closed
    {5'b01000, 4'b1010, 1'b1, 7'b1101011},  // R4 R5 gate open
    {5'b01100, 4'b1111, 1'b0, 7'b1100000},  // R4 bit2 no effect
    {5'b10000, 4'b0000, 1'b1, 7'b1100001},  // R7 R8 pins ignored
    {5'b10101, 4'b1111, 1'b1, 7'b1110101},  // R6 R7 R8
    {5'b11010, 4'b0000, 1'b0, 7'b1101010},  // R6 R7
    {5'b11111, 4'b1010, 1'b1, 7'b1111111},  // R6 R7 R8
    {5'b00110, 4'b0000, 1'b1, 7'b1011110}   // R3 R4 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); mcr_wr = 1; mcr_wdata = d;
    @(negedge clk); mcr_wr = 0;
  endtask

  task automatic alt(input logic v);
    @(negedge clk); alt_loop_wr = 1; alt_loop_val = v;
    @(negedge clk); alt_loop_wr = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    check("R1 reset", {mcr_rdata, loop_en, dtr_n_pin, rts_n_pin, irq_out}, {8'h00, 4'b0110});
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 9; i++) begin
      wr({3'b000, VECS[i][16:12]});
      {dsr_n_pin, cts_n_pin, ri_n_pin, dcd_n_pin} = VECS[i][11:8];
      irq_raw = VECS[i][7];
      #1;
      check("R2 readback", mcr_rdata, {3'b000, VECS[i][16:12]});
      check("R3-R8 vector outputs", {dtr_n_pin, rts_n_pin, dsr, cts, ri, dcd, irq_out}, VECS[i][6:0]);
    end

    wr(8'hFF);
    #1 check("R2 reserved zero", mcr_rdata, 8'h1F);
    @(negedge clk);
    check("R2 hold", mcr_rdata, 8'h1F);

    wr(8'h05);
    dsr_n_pin = 1; ri_n_pin = 1;
    alt(1'b1);
    #1;
    check("R9 alias set", {mcr_rdata, loop_en}, {8'h15, 1'b1});
    check("R9 looped dsr ri", {dsr, ri, dtr_n_pin}, 3'b111);
    alt(1'b0);
    #1 check("R9 alias clear", {mcr_rdata, loop_en, dtr_n_pin}, {8'h05, 1'b0, 1'b0});

    @(negedge clk); mcr_wr = 1; mcr_wdata = 8'h02; alt_loop_wr = 1; alt_loop_val = 1;
    @(negedge clk); mcr_wr = 0; alt_loop_wr = 0;
    #1 check("R10 mcr wins clear", {mcr_rdata, loop_en}, {8'h02, 1'b0});
    @(negedge clk); mcr_wr = 1; mcr_wdata = 8'h11; alt_loop_wr = 1; alt_loop_val = 0;
    @(negedge clk); mcr_wr = 0; alt_loop_wr = 0;
    #1 check("R10 mcr wins set", {mcr_rdata, loop_en}, {8'h11, 1'b1});

    irq_raw = 1;
    #1 check("R8 irq forced bit3 clear", irq_out, 1'b1);

    @(negedge clk); rst_n = 0;
    #1 check("R1 reset mid-run", {mcr_rdata, loop_en, dtr_n_pin, rts_n_pin, irq_out}, {8'h00, 4'b0110});
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule